// File: doc/BRIEF.md
# Self-Triggered Hit Detector with Timestamping

This block is the digital end of one detector channel. It watches a continuous stream of ADC samples and decides, with no trigger or accept input, when a pulse is present. A slowly moving baseline is tracked and subtracted before any decision is made. A pulse is recognised either as soon as it crosses a threshold (leading-edge mode) or once it has fallen back, reporting its maximum (peak mode). The mode is chosen by a plain configuration pin.

Each hit becomes one record. The record holds an amplitude, a time of arrival and a loss count. The time is an absolute sample count with a 4-bit interpolated fraction appended below it. Records are queued in a small FIFO and offered to a concentrator over a valid/ready stream. The consumer may hold `hit_ready` low for any length of time. While it does, the record at the head stays on the outputs unchanged. The sample input cannot be stalled: an ADC never waits, so it carries a valid strobe and no ready. Any hit that finds the FIFO full is counted and discarded.

Top module: `selftrig_hit_detector`

## Requirements
- R1: Every cycle with `smp_valid` high is one sample. The first sample after reset loads the baseline directly and never makes a hit. While armed, a sample whose value minus the baseline is greater than or equal to `cfg_threshold` starts a pulse; one count below the threshold does not.
- R2: While armed and below threshold, the baseline follows an exponential average with weight 1/2^BL_SHIFT. Its accumulator holds the baseline times 2^BL_SHIFT and moves by (sample minus baseline) per sample. It is frozen on the crossing sample and for the whole pulse, and it settles exactly on a constant input.
- R3: In leading-edge mode (`cfg_peak_mode` = 0), one record is produced for the crossing sample. Its amplitude is that sample minus the baseline.
- R4: In peak mode (`cfg_peak_mode` = 1), nothing is produced at the crossing. One record is produced when the pulse ends, and its amplitude is the largest baseline-subtracted sample seen during the pulse.
- R5: Samples are numbered from 0 after reset, and cycles without `smp_valid` are not counted. Take a crossing at sample k, with baseline-subtracted values dp before it and d at it, and threshold T. Then `hit_time` = 16*(k-1) + floor(16*(T-dp)/(d-dp)), where bits [3:0] are the fraction. When d equals T this gives 16*k. In both modes the time is that of the crossing.
- R6: A pulse ends, and the detector re-arms, on the first sample whose baseline-subtracted value is below `cfg_threshold` minus `cfg_hysteresis`. Until then no new hit can start.
- R7: Records leave in the order they were found. `hit_valid` stays high and the record fields stay unchanged while `hit_ready` is low. A record is removed on a cycle with both high.
- R8: A hit that arrives while the FIFO holds FIFO_DEPTH records is dropped, even if a record is read in the same cycle. The number of dropped hits (saturating) is reported in `hit_lost` of the next record that is stored, and the count then clears to 0.
- R9: After reset, `hit_valid` is low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_peak_mode | input | 1 | 0 = leading-edge, 1 = peak mode; change only between pulses |
| cfg_threshold | input | SAMPLE_W | Hit threshold above baseline |
| cfg_hysteresis | input | SAMPLE_W | Re-arm margin below threshold |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Unsigned ADC sample (SAMPLE_W from 8 to 12) |
| hit_valid | output | 1 | Record available |
| hit_ready | input | 1 | Consumer accepts record |
| hit_time | output | TS_W+4 | Coarse sample count with 4-bit fraction |
| hit_amp | output | SAMPLE_W | Baseline-subtracted amplitude |
| hit_lost | output | LOST_W | Hits dropped before this record |

## Verification
The embedded properties watch, on every cycle, several invariants. A head record held under back-pressure does not change. No write lands in a full queue, and occupancy never exceeds the depth. The baseline does not move outside the armed, below-threshold condition. Each interpolated fraction brackets the true ratio. Every emitted amplitude reaches the threshold, and no two events come from adjacent cycles. The exact values need the directed scenarios to show them: absolute times, with and without strobe gaps; the difference between the two modes; the effect of the hysteresis margin; baseline settling after a step; and the loss count carried into the next stored record.

// File: rtl/hitdet_pkg.sv
package hitdet_pkg;
  localparam int FRAC_W = 4;

  typedef enum logic {
    TRIG_ARMED = 1'b0,
    TRIG_PULSE = 1'b1
  } trig_state_e;
endpackage

// File: rtl/hitdet_baseline.sv
module hitdet_baseline #(
  parameter int SAMPLE_W = 12,
  parameter int BL_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                upd_en,
  output logic [SAMPLE_W-1:0] bl,
  output logic                bl_ok
);
  localparam int ACC_W = SAMPLE_W + BL_SHIFT;

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   acc_nxt;

  assign bl = acc[ACC_W-1:BL_SHIFT];

  // acc never drops below its own integer part, so the sum stays positive
  always_comb acc_nxt = {1'b0, acc} + (ACC_W+1)'(smp_data) - (ACC_W+1)'(bl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      bl_ok <= 1'b0;
    end else if (smp_valid) begin
      if (!bl_ok) begin
        acc   <= {smp_data, {BL_SHIFT{1'b0}}};
        bl_ok <= 1'b1;
      end else if (upd_en) begin
        acc <= acc_nxt[ACC_W-1:0];
      end
    end
  end

  p_bl_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_ok && !(smp_valid && upd_en)) |=> $stable(bl));

  p_bl_rises_toward_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_ok && smp_valid && upd_en && (smp_data > bl)) |=> (bl >= $past(bl)));
endmodule

// File: rtl/hitdet_trigger.sv
module hitdet_trigger
  import hitdet_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int TS_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic                       bl_ok,
  input  logic signed [SAMPLE_W+1:0] diff,
  input  logic [TS_W-1:0]            smp_idx,
  input  logic                       cfg_peak_mode,
  input  logic [SAMPLE_W-1:0]        cfg_threshold,
  input  logic [SAMPLE_W-1:0]        cfg_hysteresis,
  output logic                       upd_en,
  output logic                       ev_valid,
  output logic [SAMPLE_W+1:0]        ev_num,
  output logic [SAMPLE_W+1:0]        ev_den,
  output logic [TS_W-1:0]            ev_coarse,
  output logic [SAMPLE_W-1:0]        ev_amp
);
  localparam int DW = SAMPLE_W + 2;

  trig_state_e          state;
  logic signed [DW-1:0] d_prev;
  logic signed [DW-1:0] thr_s, rearm_lvl;
  logic [DW-1:0]        num_now, den_now;
  logic [DW-1:0]        cr_num, cr_den;
  logic [TS_W-1:0]      cr_coarse;
  logic [SAMPLE_W-1:0]  pk;
  logic                 above, under_rearm, take;

  assign thr_s       = $signed({2'b00, cfg_threshold});
  assign rearm_lvl   = thr_s - $signed({2'b00, cfg_hysteresis});
  assign above       = diff >= thr_s;
  assign under_rearm = diff < rearm_lvl;
  assign num_now     = thr_s - d_prev;
  assign den_now     = diff - d_prev;
  assign take        = smp_valid && bl_ok;
  assign upd_en      = take && (state == TRIG_ARMED) && !above;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= TRIG_ARMED;
      d_prev    <= '0;
      cr_num    <= '0;
      cr_den    <= '0;
      cr_coarse <= '0;
      pk        <= '0;
      ev_valid  <= 1'b0;
      ev_num    <= '0;
      ev_den    <= '0;
      ev_coarse <= '0;
      ev_amp    <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (take) begin
        d_prev <= diff;
        unique case (state)
          TRIG_ARMED: if (above) begin
            state     <= TRIG_PULSE;
            cr_num    <= num_now;
            cr_den    <= den_now;
            cr_coarse <= smp_idx - TS_W'(1);
            pk        <= diff[SAMPLE_W-1:0];
            if (!cfg_peak_mode) begin
              ev_valid  <= 1'b1;
              ev_num    <= num_now;
              ev_den    <= den_now;
              ev_coarse <= smp_idx - TS_W'(1);
              ev_amp    <= diff[SAMPLE_W-1:0];
            end
          end
          TRIG_PULSE: if (under_rearm) begin
            state <= TRIG_ARMED;
            if (cfg_peak_mode) begin
              ev_valid  <= 1'b1;
              ev_num    <= cr_num;
              ev_den    <= cr_den;
              ev_coarse <= cr_coarse;
              ev_amp    <= pk;
            end
          end else if (diff > $signed({2'b00, pk})) begin
            pk <= diff[SAMPLE_W-1:0];
          end
          default: state <= TRIG_ARMED;
        endcase
      end else if (smp_valid) begin
        d_prev <= '0;
      end
    end
  end

  p_event_needs_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(smp_valid));

  p_no_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);

  p_amp_reaches_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_amp >= cfg_threshold));

  p_interp_ordered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ((ev_num != '0) && (ev_num <= ev_den)));
endmodule

// File: rtl/hitdet_finetime.sv
module hitdet_finetime #(
  parameter int NW     = 14,
  parameter int FRAC_W = 4
) (
  input  logic [NW-1:0]   num,
  input  logic [NW-1:0]   den,
  output logic [FRAC_W:0] q
);
  logic [NW:0]       rem;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    rem  = {1'b0, num};
    frac = '0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      rem = rem << 1;
      if (rem >= {1'b0, den}) begin
        frac[i] = 1'b1;
        rem     = rem - {1'b0, den};
      end
    end
    q = (num >= den) ? (FRAC_W+1)'(1 << FRAC_W) : {1'b0, frac};
  end

  // R5: quotient brackets num*2^FRAC_W / den from below
  always_comb begin
    if (den != '0 && num <= den) begin
      a_fine_bracket_r5: assert ((64'(q) * 64'(den) <= (64'(num) << FRAC_W)) &&
                                 ((64'(q) + 64'd1) * 64'(den) > (64'(num) << FRAC_W)))
        else $error("fine time out of bracket");
    end
  end
endmodule

// File: rtl/hitdet_fifo.sv
module hitdet_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             pop;

  assign full     = cnt == (AW+1)'(DEPTH);
  assign rd_valid = cnt != '0;
  assign rd_data  = mem[rp];
  assign pop      = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)   rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + (AW+1)'(wr_en) - (AW+1)'(pop);
    end
  end

  p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_no_write_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);

  p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/selftrig_hit_detector.sv
module selftrig_hit_detector
  import hitdet_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int TS_W       = 16,
  parameter int BL_SHIFT   = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int LOST_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_peak_mode,
  input  logic [SAMPLE_W-1:0]      cfg_threshold,
  input  logic [SAMPLE_W-1:0]      cfg_hysteresis,
  input  logic                     smp_valid,
  input  logic [SAMPLE_W-1:0]      smp_data,
  output logic                     hit_valid,
  input  logic                     hit_ready,
  output logic [TS_W+FRAC_W-1:0]   hit_time,
  output logic [SAMPLE_W-1:0]      hit_amp,
  output logic [LOST_W-1:0]        hit_lost
);
  localparam int DW     = SAMPLE_W + 2;
  localparam int TIME_W = TS_W + FRAC_W;
  localparam int REC_W  = LOST_W + SAMPLE_W + TIME_W;

  logic [TS_W-1:0]      smp_idx;
  logic [SAMPLE_W-1:0]  bl;
  logic                 bl_ok, upd_en;
  logic signed [DW-1:0] diff;
  logic                 ev_valid;
  logic [DW-1:0]        ev_num, ev_den;
  logic [TS_W-1:0]      ev_coarse;
  logic [SAMPLE_W-1:0]  ev_amp;
  logic [FRAC_W:0]      q;
  logic [TIME_W-1:0]    ev_time;
  logic [LOST_W-1:0]    lost;
  logic                 fifo_full, push;
  logic [REC_W-1:0]     rec_in, rec_out;

  always_ff @(posedge clk) begin
    if (!rst_n)         smp_idx <= '0;
    else if (smp_valid) smp_idx <= smp_idx + TS_W'(1);
  end

  assign diff = $signed({2'b00, smp_data}) - $signed({2'b00, bl});

  hitdet_baseline #(.SAMPLE_W(SAMPLE_W), .BL_SHIFT(BL_SHIFT)) u_baseline (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .upd_en(upd_en), .bl(bl), .bl_ok(bl_ok)
  );

  hitdet_trigger #(.SAMPLE_W(SAMPLE_W), .TS_W(TS_W)) u_trigger (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .bl_ok(bl_ok),
    .diff(diff), .smp_idx(smp_idx), .cfg_peak_mode(cfg_peak_mode),
    .cfg_threshold(cfg_threshold), .cfg_hysteresis(cfg_hysteresis),
    .upd_en(upd_en), .ev_valid(ev_valid), .ev_num(ev_num), .ev_den(ev_den),
    .ev_coarse(ev_coarse), .ev_amp(ev_amp)
  );

  hitdet_finetime #(.NW(DW), .FRAC_W(FRAC_W)) u_finetime (
    .num(ev_num), .den(ev_den), .q(q)
  );

  assign ev_time = {ev_coarse, {FRAC_W{1'b0}}} + TIME_W'(q);
  assign push    = ev_valid && !fifo_full;
  assign rec_in  = {lost, ev_amp, ev_time};

  always_ff @(posedge clk) begin
    if (!rst_n) lost <= '0;
    else if (ev_valid) begin
      if (!fifo_full)    lost <= '0;
      else if (lost != '1) lost <= lost + LOST_W'(1);
    end
  end

  hitdet_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(rec_in), .full(fifo_full),
    .rd_valid(hit_valid), .rd_ready(hit_ready), .rd_data(rec_out)
  );

  assign {hit_lost, hit_amp, hit_time} = rec_out;
endmodule

// File: tb/selftrig_hit_detector_tb.sv
module selftrig_hit_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_peak_mode = 1'b0;
  logic [11:0] cfg_threshold = 12'd40;
  logic [11:0] cfg_hysteresis = 12'd10;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        hit_valid;
  logic        hit_ready = 1'b0;
  logic [19:0] hit_time;
  logic [11:0] hit_amp;
  logic [7:0]  hit_lost;

  int n_chk = 0, n_bad = 0, sidx = 0, last_k = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  selftrig_hit_detector u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_peak_mode(cfg_peak_mode),
    .cfg_threshold(cfg_threshold), .cfg_hysteresis(cfg_hysteresis),
    .smp_valid(smp_valid), .smp_data(smp_data), .hit_valid(hit_valid),
    .hit_ready(hit_ready), .hit_time(hit_time), .hit_amp(hit_amp), .hit_lost(hit_lost)
  );

  function automatic int et(input int k, input int q);
    return (k - 1) * 16 + q;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int x);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = 12'(x);
    last_k    = sidx;
    sidx++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic pop(input int t, input int amp, input int lst, input string req);
    int w = 0;
    while (!hit_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    chk(hit_valid == 1'b1, {req, " record present"}, int'(hit_valid), 1);
    chk(int'(hit_time) == t, {req, " time"}, int'(hit_time), t);
    chk(int'(hit_amp) == amp, {req, " amplitude"}, int'(hit_amp), amp);
    chk(int'(hit_lost) == lst, {req, " lost count"}, int'(hit_lost), lst);
    hit_ready = 1'b1;
    @(negedge clk);
    hit_ready = 1'b0;
  endtask

  task automatic none(input string req);
    chk(hit_valid == 1'b0, {req, " no record"}, int'(hit_valid), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    sidx = 0;
    @(negedge clk);
    none("R9 after reset");
  endtask

  task automatic t_leading_edge;
    int k;
    repeat (4) send(100);
    send(180); k = last_k;
    send(100); send(100);
    idle(4);
    pop(et(k, 8), 80, 0, "R3/R5 leading edge");
    none("R1 single hit");
  endtask

  task automatic t_hysteresis;
    int k1, k2;
    send(100); send(180); k1 = last_k;
    send(135); send(180); send(100); send(100);
    idle(4);
    pop(et(k1, 8), 80, 0, "R6 margin holds");
    none("R6 dip inside margin");
    cfg_hysteresis = 12'd0;
    send(100); send(180); k1 = last_k;
    send(135); send(180); k2 = last_k;
    send(100);
    idle(4);
    pop(et(k1, 8), 80, 0, "R6 zero margin first");
    pop(et(k2, 1), 80, 0, "R6 zero margin second");
    none("R6 zero margin");
    cfg_hysteresis = 12'd10;
  endtask

  task automatic t_peak;
    int k;
    cfg_peak_mode = 1'b1;
    send(100); send(100); send(170); k = last_k;
    send(200); send(250); send(190);
    idle(4);
    none("R4 nothing at crossing");
    send(135);
    idle(3);
    none("R4/R6 inside margin");
    send(125); send(100);
    idle(4);
    pop(et(k, 9), 150, 0, "R4 peak");
    none("R4 single record");
    cfg_peak_mode = 1'b0;
  endtask

  task automatic t_gaps;
    int k;
    send(100); idle(2); send(100); idle(1);
    send(180); k = last_k;
    idle(1); send(100);
    idle(4);
    pop(et(k, 8), 80, 0, "R5 strobe gaps");
  endtask

  task automatic t_backpressure;
    int k, k2;
    send(100); send(180); k = last_k; send(100);
    send(100); send(180); k2 = last_k; send(100);
    idle(4);
    chk(hit_valid == 1'b1, "R7 valid under stall", int'(hit_valid), 1);
    idle(6);
    chk(hit_valid == 1'b1, "R7 valid held", int'(hit_valid), 1);
    chk(int'(hit_time) == et(k, 8), "R7 time held", int'(hit_time), et(k, 8));
    pop(et(k, 8), 80, 0, "R7 first in order");
    pop(et(k2, 8), 80, 0, "R7 second in order");
    none("R7 drained");
  endtask

  task automatic t_overflow;
    int ks[6];
    int k;
    for (int i = 0; i < 6; i++) begin
      send(100); send(180); ks[i] = last_k; send(100);
    end
    idle(4);
    for (int i = 0; i < 4; i++) pop(et(ks[i], 8), 80, 0, "R8 stored");
    none("R8 dropped hits absent");
    send(100); send(180); k = last_k; send(100);
    idle(4);
    pop(et(k, 8), 80, 2, "R8 loss reported");
    send(100); send(180); k = last_k; send(100);
    idle(4);
    pop(et(k, 8), 80, 0, "R8 loss cleared");
  endtask

  task automatic t_threshold;
    int k;
    send(100); send(140); k = last_k; send(100);
    idle(4);
    pop(k * 16, 40, 0, "R1/R5 equal to threshold");
    send(100); send(139);
    repeat (40) send(100);
    idle(4);
    none("R1 one below threshold");
  endtask

  task automatic t_drift;
    int k;
    repeat (150) send(120);
    idle(4);
    none("R2 step below threshold");
    send(120); send(200); k = last_k; send(120);
    idle(4);
    pop(et(k, 8), 80, 0, "R2 baseline settled");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_leading_edge();
    t_hysteresis();
    t_peak();
    t_gaps();
    t_backpressure();
    t_overflow();
    t_threshold();
    t_drift();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule